// File: doc/BRIEF.md
# Coarse-Fine Hit Interval Timer

This block times the gap between consecutive hit pulses. Each hit comes with a one-cycle snapshot of a tapped delay line. Tap `i` reads 1 when the hit edge has travelled past cell `i` before the sampling clock edge, so a clean snapshot holds a run of ones from tap 0 upward. The block cleans isolated bubbles out of the snapshot and turns the run length into a fine tap index. It pairs that index with a coarse clock-period count and so forms a timestamp for the hit. It then subtracts the timestamp of the previous accepted hit.

Two free-running binary period counters supply the coarse count. One advances on the rising clock edge and one on the falling edge. The falling-edge counter starts only after the first rising edge, so that the two counters always agree at a sampling edge. For hits whose index lies in the half of the line nearest the sampling edge, the count comes from the falling-edge counter. That counter was last updated half a period earlier and is settled.

Each result is offered on a valid/ready output. It carries the fine difference, the coarse difference and the combined interval in picoseconds. The output has one holding register. A result that arrives while that register is still waiting for ready is dropped and counted.

Top module: `tdc_interval_meter`

## Requirements
- R1: While reset is asserted and just after it, `res_valid_o` and `code_bad_o` are 0 and `drop_cnt_o` is 0.
- R2: Before the index is taken, each tap is replaced by the majority of itself and its two neighbours. Below tap 0 counts as 1 and above the top tap counts as 0. The fine index is the position of the first 0 in the cleaned snapshot, or NTAPS if there is none. `res_fine_o` equals the previous accepted index minus the new index, as a signed value.
- R3: A single tap that differs from both of its neighbours does not change the index. This holds for a 0 inside the run of ones and for a 1 above it, including at tap 0 and at the top tap.
- R4: A raw snapshot of all zeros or all ones is rejected. `code_bad_o` is high for exactly the cycle that follows the second rising edge after the sampling edge. No result is produced and the stored previous timestamp is left unchanged.
- R5: `res_coarse_o` equals the number of rising edges from the previous accepted hit's sampling edge to this one, modulo 2^CW.
- R6: `res_ps_o` equals `res_fine_o`*TAP_PS + `res_coarse_o`*CLK_PS, with the coarse part treated as unsigned.
- R7: The first accepted hit after reset produces no result.
- R8: A result becomes valid right after the third rising edge that follows its hit's sampling edge.
- R9: While `res_valid_o` is 1 and `res_ready_i` is 0, all result fields are held. A transfer clears valid, unless a new result loads on the same edge.
- R10: A result that arrives while the held result is stalled is dropped, and `drop_cnt_o` increments, saturating at all ones. The dropped hit still becomes the previous timestamp.
- R11: At every sampling edge after the first, the rising and falling counters hold equal values. The coarse count comes from the falling counter for indices below NTAPS/2 and from the rising counter otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; both edges are used by the coarse counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Hit present in this cycle's snapshot |
| taps_i | input | NTAPS | Delay line snapshot, tap 0 nearest the hit entry |
| res_ready_i | input | 1 | Consumer accepts the offered result |
| res_valid_o | output | 1 | Result offered |
| res_fine_o | output | IDXW+1 | Signed fine difference in taps |
| res_coarse_o | output | CW | Coarse difference in clock periods |
| res_ps_o | output | PSW | Signed combined interval in picoseconds |
| code_bad_o | output | 1 | One-cycle flag for a rejected snapshot |
| drop_cnt_o | output | DROPW | Saturating count of dropped results |

## Verification
Three things can meet on one clock edge: a new result reaching the holding register, the consumer taking or refusing the held result, and a rejected snapshot flagging while an earlier good hit is still in flight. The bench sends hits on every cycle, mixes valid and invalid snapshots, and toggles ready in a pattern that is out of step with the hits. Load, transfer, stall-drop and flag then coincide in every combination. A behavioural model updates after each rising edge and decides each case on its own: it applies a transfer and a load together and drops only on a refused stall. The bench compares the model's valid, fields, flag and drop count with the ports on every cycle.

// File: rtl/tdc_ts_pkg.sv
package tdc_ts_pkg;

  // majority of three neighbouring taps: removes a single-tap bubble
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // combined interval: fine taps plus coarse periods, in picoseconds
  function automatic int interval_ps(input int fine, input int coarse,
                                     input int tap_ps, input int clk_ps);
    return fine * tap_ps + coarse * clk_ps;
  endfunction

  // saturating increment for an event counter held in an int range
  function automatic int sat_inc(input int value, input int max_value);
    return (value >= max_value) ? max_value : value + 1;
  endfunction

endpackage

// File: rtl/tdl_bubble_filter.sv
module tdl_bubble_filter
  import tdc_ts_pkg::*;
#(
  parameter int N = 200
) (
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] clean_o
);

  for (genvar i = 0; i < N; i++) begin : g_tap
    logic below;
    logic above;
    if (i == 0) begin : g_lo
      assign below = 1'b1;
    end else begin : g_lo_n
      assign below = raw_i[i-1];
    end
    if (i == N - 1) begin : g_hi
      assign above = 1'b0;
    end else begin : g_hi_n
      assign above = raw_i[i+1];
    end
    assign clean_o[i] = maj3(below, raw_i[i], above);
  end

endmodule

// File: rtl/tdl_thermo_encode.sv
module tdl_thermo_encode #(
  parameter int N  = 200,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  raw_i,
  input  logic [N-1:0]  clean_i,
  output logic [IW-1:0] idx_o,
  output logic          ok_o
);

  logic found;

  always_comb begin
    idx_o = IW'(N);
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && !clean_i[i]) begin
        idx_o = IW'(i);
        found = 1'b1;
      end
    end
  end

  // a snapshot with no edge in it carries no timing information
  assign ok_o = (|raw_i) && !(&raw_i);

endmodule

// File: rtl/tdc_coarse_counters.sv
module tdc_coarse_counters #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_rise_o,
  output logic [CW-1:0] cnt_fall_o,
  output logic          run_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_rise_o <= '0;
      run_o      <= 1'b0;
    end else begin
      cnt_rise_o <= cnt_rise_o + CW'(1);
      run_o      <= 1'b1;
    end
  end

  // held until the first rising edge so both counters agree at every sample
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_fall_o <= '0;
    end else if (run_o) begin
      cnt_fall_o <= cnt_fall_o + CW'(1);
    end
  end

endmodule

// File: rtl/tdc_interval_meter.sv
module tdc_interval_meter
  import tdc_ts_pkg::*;
#(
  parameter int NTAPS  = 200,
  parameter int TAP_PS = 25,
  parameter int CLK_PS = 4000,
  parameter int CW     = 16,
  parameter int PSW    = 32,
  parameter int DROPW  = 8,
  parameter int IDXW   = $clog2(NTAPS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hit_i,
  input  logic [NTAPS-1:0]       taps_i,
  input  logic                   res_ready_i,
  output logic                   res_valid_o,
  output logic signed [IDXW:0]   res_fine_o,
  output logic [CW-1:0]          res_coarse_o,
  output logic signed [PSW-1:0]  res_ps_o,
  output logic                   code_bad_o,
  output logic [DROPW-1:0]       drop_cnt_o
);

  localparam int HALF     = NTAPS / 2;
  localparam int FALL_ADJ = 0;  // falling count already pairs with this edge
  localparam int DROP_MAX = (1 << DROPW) - 1;

  // coarse counters
  logic [CW-1:0] cnt_rise, cnt_fall;
  logic          run;

  tdc_coarse_counters #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_rise_o (cnt_rise),
    .cnt_fall_o (cnt_fall),
    .run_o      (run)
  );

  // stage 1: capture snapshot and both counts
  logic             s1_v;
  logic [NTAPS-1:0] s1_taps;
  logic [CW-1:0]    s1_cr, s1_cf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_taps <= '0;
      s1_cr   <= '0;
      s1_cf   <= '0;
    end else begin
      s1_v <= hit_i;
      if (hit_i) begin
        s1_taps <= taps_i;
        s1_cr   <= cnt_rise;
        s1_cf   <= cnt_fall;
      end
    end
  end

  // stage 1 -> 2: bubble removal and encoding
  logic [NTAPS-1:0] s1_clean;
  logic [IDXW-1:0]  s1_idx;
  logic             s1_ok;
  logic [CW-1:0]    s1_coarse;

  tdl_bubble_filter #(.N(NTAPS)) u_filt (
    .raw_i   (s1_taps),
    .clean_o (s1_clean)
  );

  tdl_thermo_encode #(.N(NTAPS), .IW(IDXW)) u_enc (
    .raw_i   (s1_taps),
    .clean_i (s1_clean),
    .idx_o   (s1_idx),
    .ok_o    (s1_ok)
  );

  assign s1_coarse = (s1_idx < IDXW'(HALF)) ? (s1_cf + CW'(FALL_ADJ)) : s1_cr;

  // stage 2: timestamp
  logic            s2_v, s2_ok;
  logic [IDXW-1:0] s2_idx;
  logic [CW-1:0]   s2_coarse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v      <= 1'b0;
      s2_ok     <= 1'b0;
      s2_idx    <= '0;
      s2_coarse <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_ok     <= s1_ok;
        s2_idx    <= s1_idx;
        s2_coarse <= s1_coarse;
      end
    end
  end

  // stage 3: difference against previous accepted timestamp
  logic                s3_v;
  logic signed [IDXW:0] s3_fine;
  logic [CW-1:0]       s3_coarse;
  logic [IDXW-1:0]     prev_idx;
  logic [CW-1:0]       prev_coarse;
  logic                have_prev;
  logic                s2_accept;

  assign s2_accept = s2_v && s2_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_v        <= 1'b0;
      s3_fine     <= '0;
      s3_coarse   <= '0;
      prev_idx    <= '0;
      prev_coarse <= '0;
      have_prev   <= 1'b0;
      code_bad_o  <= 1'b0;
    end else begin
      s3_v       <= 1'b0;
      code_bad_o <= s2_v && !s2_ok;
      if (s2_accept) begin
        if (have_prev) begin
          s3_v      <= 1'b1;
          s3_fine   <= $signed({1'b0, prev_idx}) - $signed({1'b0, s2_idx});
          s3_coarse <= s2_coarse - prev_coarse;
        end
        prev_idx    <= s2_idx;
        prev_coarse <= s2_coarse;
        have_prev   <= 1'b1;
      end
    end
  end

  // output holding register with valid/ready
  logic res_load;
  logic res_stalled;

  assign res_load    = s3_v;
  assign res_stalled = res_valid_o && !res_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o  <= 1'b0;
      res_fine_o   <= '0;
      res_coarse_o <= '0;
      res_ps_o     <= '0;
      drop_cnt_o   <= '0;
    end else if (res_load) begin
      if (res_stalled) begin
        drop_cnt_o <= DROPW'(sat_inc(int'(drop_cnt_o), DROP_MAX));
      end else begin
        res_valid_o  <= 1'b1;
        res_fine_o   <= s3_fine;
        res_coarse_o <= s3_coarse;
        res_ps_o     <= PSW'(interval_ps(int'(s3_fine), int'(s3_coarse), TAP_PS, CLK_PS));
      end
    end else if (res_ready_i) begin
      res_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/tdc_interval_meter_chk.sv
module tdc_interval_meter_chk #(
  parameter int NTAPS = 200,
  parameter int CW    = 16,
  parameter int PSW   = 32,
  parameter int DROPW = 8,
  parameter int IDXW  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  res_valid_o,
  input logic                  res_ready_i,
  input logic signed [IDXW:0]  res_fine_o,
  input logic [CW-1:0]         res_coarse_o,
  input logic signed [PSW-1:0] res_ps_o,
  input logic                  code_bad_o,
  input logic [DROPW-1:0]      drop_cnt_o,
  input logic                  run,
  input logic [CW-1:0]         cnt_rise,
  input logic [CW-1:0]         cnt_fall,
  input logic                  s2_v,
  input logic                  s2_ok,
  input logic [IDXW-1:0]       s2_idx,
  input logic                  have_prev,
  input logic                  res_load
);

  // R11: the two edge counters agree at every sampling edge once running
  a_r11_counters_agree: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_rise == cnt_fall);

  // R2: the encoded index never leaves 0..NTAPS
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v |-> s2_idx <= IDXW'(NTAPS));

  // R4: a rejected snapshot raises the flag on the next edge
  a_r4_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && !s2_ok) |=> code_bad_o);

  // R7: the first accepted timestamp produces no result
  a_r7_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && s2_ok && !have_prev) |=> !res_load);

  // R8: a result reaching the output stage is offered next cycle
  a_r8_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_load |=> res_valid_o);

  // R9: stalled result is held unchanged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> res_valid_o && $stable(res_fine_o)
      && $stable(res_coarse_o) && $stable(res_ps_o));

  // R10: drop counter moves by at most one step
  a_r10_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_cnt_o == $past(drop_cnt_o))
          || (drop_cnt_o == $past(drop_cnt_o) + DROPW'(1)));

  // R10: a refused load below saturation bumps the counter
  a_r10_drop_bump: assert property (@(posedge clk) disable iff (!rst_n)
    (res_load && res_valid_o && !res_ready_i && drop_cnt_o != '1)
      |=> drop_cnt_o == $past(drop_cnt_o) + DROPW'(1));

endmodule

bind tdc_interval_meter tdc_interval_meter_chk #(
  .NTAPS(NTAPS), .CW(CW), .PSW(PSW), .DROPW(DROPW), .IDXW(IDXW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_valid_o  (res_valid_o),
  .res_ready_i  (res_ready_i),
  .res_fine_o   (res_fine_o),
  .res_coarse_o (res_coarse_o),
  .res_ps_o     (res_ps_o),
  .code_bad_o   (code_bad_o),
  .drop_cnt_o   (drop_cnt_o),
  .run          (run),
  .cnt_rise     (cnt_rise),
  .cnt_fall     (cnt_fall),
  .s2_v         (s2_v),
  .s2_ok        (s2_ok),
  .s2_idx       (s2_idx),
  .have_prev    (have_prev),
  .res_load     (res_load)
);

// File: tb/tb_tdc_interval_meter.sv
`timescale 1ns/1ps
module tb_tdc_interval_meter;

  localparam int NT   = 200;
  localparam int TAP  = 25;
  localparam int CPS  = 4000;
  localparam int CMOD = 65536;
  localparam int DMAX = 255;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hit = 1'b0;
  logic [NT-1:0]    taps = '0;
  logic             ready = 1'b1;
  logic             res_valid;
  logic signed [8:0]  res_fine;
  logic [15:0]      res_coarse;
  logic signed [31:0] res_ps;
  logic             code_bad;
  logic [7:0]       drop_cnt;

  always #2 clk = ~clk;  // 250 MHz

  tdc_interval_meter dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .taps_i(taps),
    .res_ready_i(ready), .res_valid_o(res_valid), .res_fine_o(res_fine),
    .res_coarse_o(res_coarse), .res_ps_o(res_ps), .code_bad_o(code_bad),
    .drop_cnt_o(drop_cnt)
  );

  int compared = 0;
  int mismatched = 0;

  // behavioural model state
  int edge_n = 0;
  int prev_k = 0, prev_e = 0;
  bit have_prev = 0;
  int q_due[$], q_fine[$], q_coarse[$];
  int bad_due[$];
  bit mv = 0, mbad = 0;
  int mf = 0, mc = 0, mdrop = 0;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, exp, edge_n);
    end
  endtask

  function automatic logic [NT-1:0] thermo(input int k);
    logic [NT-1:0] p;
    for (int i = 0; i < NT; i++) p[i] = (i < k);
    return p;
  endfunction

  task automatic compare_all();
    check("R8 R9", "valid", longint'(res_valid), longint'(mv));
    if (mv && res_valid) begin
      check("R2", "fine", longint'(res_fine), longint'(mf));
      check("R5", "coarse", longint'(res_coarse), longint'(mc));
      check("R6", "ps", longint'(res_ps), longint'(mf * TAP + mc * CPS));
    end
    check("R4", "code_bad", longint'(code_bad), longint'(mbad));
    check("R10", "drop", longint'(drop_cnt), longint'(mdrop));
  endtask

  // one clock: inputs held from negedge to negedge, model updated after the edge
  task automatic tick(input bit h, input logic [NT-1:0] pat, input int k,
                      input bit good, input bit rdy);
    bit load;
    hit = h; taps = pat; ready = rdy;
    @(posedge clk);
    @(negedge clk);
    edge_n++;
    if (h) begin
      if (good) begin
        if (have_prev) begin
          q_due.push_back(edge_n + 3);
          q_fine.push_back(prev_k - k);
          q_coarse.push_back((edge_n - prev_e) % CMOD);
        end
        prev_k = k; prev_e = edge_n; have_prev = 1;
      end else begin
        bad_due.push_back(edge_n + 2);
      end
    end
    load = (q_due.size() > 0) && (q_due[0] == edge_n);
    if (load) begin
      if (mv && !rdy) begin
        if (mdrop < DMAX) mdrop++;
      end else begin
        mv = 1; mf = q_fine[0]; mc = q_coarse[0];
      end
      void'(q_due.pop_front()); void'(q_fine.pop_front()); void'(q_coarse.pop_front());
    end else if (rdy) begin
      mv = 0;
    end
    mbad = (bad_due.size() > 0) && (bad_due[0] == edge_n);
    if (mbad) void'(bad_due.pop_front());
    compare_all();
  endtask

  task automatic hit_k(input int k, input bit rdy);
    tick(1, thermo(k), k, 1, rdy);
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int i = 0; i < n; i++) tick(0, '0, 0, 0, rdy);
  endtask

  initial begin
    #800000;
    mismatched++;
    $display("FAIL watchdog expired at edge %0d", edge_n);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [NT-1:0] p;
    repeat (3) @(negedge clk);
    // R1: state under reset
    check("R1", "valid in reset", longint'(res_valid), 0);
    check("R1", "bad in reset", longint'(code_bad), 0);
    check("R1", "drop in reset", longint'(drop_cnt), 0);
    rst_n = 1'b1;
    idle(3, 1);
    check("R1", "valid after reset", longint'(res_valid), 0);

    // R7: first hit silent; R8 latency judged by per-cycle compare
    hit_k(40, 1);
    idle(6, 1);
    check("R7", "no first result", longint'(res_valid), 0);

    // R2 R5 R6: clean patterns, both halves of the line (R11 counter choice)
    hit_k(150, 1); idle(4, 1);
    hit_k(10, 1);  idle(9, 1);
    hit_k(199, 1); idle(2, 1);
    hit_k(1, 1);   idle(5, 1);
    hit_k(99, 1);  hit_k(100, 1); idle(5, 1);

    // R3: single bubbles, inside the run, above it, at tap 0 and at the top tap
    p = thermo(120); p[60] = 1'b0;  tick(1, p, 120, 1, 1); idle(3, 1);
    p = thermo(30);  p[150] = 1'b1; tick(1, p, 30, 1, 1);  idle(3, 1);
    p = thermo(80);  p[0] = 1'b0;   tick(1, p, 80, 1, 1);  idle(3, 1);
    p = thermo(10);  p[NT-1] = 1'b1; tick(1, p, 10, 1, 1); idle(4, 1);

    // R4: rejected snapshots leave the previous timestamp alone
    tick(1, '0, 0, 0, 1);  idle(3, 1);
    tick(1, '1, 0, 0, 1);  idle(2, 1);
    hit_k(70, 1); idle(5, 1);

    // R9 R10: stall and drop; then transfer
    hit_k(20, 1); hit_k(25, 0); idle(3, 0);
    hit_k(30, 0); hit_k(35, 0); idle(5, 0);
    idle(3, 1);

    // simultaneous load, transfer, stall and flag, hits every cycle
    for (int i = 0; i < 60; i++) begin
      bit r;
      r = (i % 3) != 0;
      if (i % 7 == 3) tick(1, (i % 2) ? '1 : '0, 0, 0, r);
      else if (i % 5 == 1) begin
        p = thermo(1 + (i * 37) % 198); p[0] = ~p[0];
        if (p == '1 || p == '0) tick(1, thermo(50), 50, 1, r);
        else tick(1, p, 1 + (i * 37) % 198, 1, r);
      end else hit_k(1 + (i * 37) % 198, r);
    end
    idle(6, 1);

    // R5: coarse count wraps modulo 2^16
    hit_k(60, 1); idle(70000, 1); hit_k(61, 1); idle(6, 1);

    // R10: saturation of the drop counter
    hit_k(90, 0);
    for (int i = 0; i < 300; i++) hit_k(90 - (i % 50), 0);
    idle(6, 0);
    check("R10", "drop saturated", longint'(drop_cnt), DMAX);
    idle(6, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule